// File: doc/BRIEF.md
# Sinc-Cubed Decimation Filter

This block turns the one-bit output of a sigma-delta modulator into signed multi-bit samples. Each accepted bit counts as +1 (one) or −1 (zero) and feeds a chain of three integrators. After every 32 accepted bits, a chain of three comb stages takes the difference and produces one sample. The response is ((1 − z^-32)/(1 − z^-1))^3 and the DC gain is 32768. The raw result is scaled to a 15-bit two's complement value.

A formatting stage chooses the output word for each sample. In the wide data format the 15-bit value is shifted left by one place with a zero LSB, and any result at or above positive full scale becomes 0x7FFF. In the flagged format the 15-bit value fills bits 14:0 and bit 15 carries the data flag. The modulator normally presents one bit every eight clock cycles, so one sample leaves every 256 cycles.

A synchronous filter clear empties every integrator and comb register. After a reset or a clear, the first three samples are marked not settled while the comb delays fill.

Top module: `sinc3_decimator`

## Requirements
- R1: After reset, smp_stb, smp_ok and smp_word are all 0 and stay so until bits are accepted.
- R2: One smp_stb pulse, one cycle long, follows every 32 accepted bits. With one bit every 8 cycles, consecutive pulses are 256 cycles apart.
- R3: bit_in is ignored in cycles where bit_en is low.
- R4: A steady stream of ones gives the positive-full-scale code: 0x7FFF in wide format and 0x3FFF in flagged format.
- R5: A steady stream of zeros gives negative full scale: 0x8000 in wide format and 0x4000 in flagged format.
- R6: In wide format (fmt_mixed = 0), smp_word is the 15-bit result shifted left with bit 0 = 0, unless the result saturates to 0x7FFF. A 3/4-ones stream gives 0x4000 and a 1/4-ones stream gives 0xC000.
- R7: In flagged format (fmt_mixed = 1), bit 15 is the data flag (0) and bits 14:0 are the 15-bit result. A 3/4-ones stream gives 0x2000 and a 1/4-ones stream gives 0x6000.
- R8: A stream that alternates between one and zero gives 0x0000 once settled.
- R9: After reset or flt_clr, the first three pulses have smp_ok = 0 and every later pulse has smp_ok = 1. smp_ok is never high without smp_stb.
- R10: flt_clr suppresses the pulse in the following cycle. It restarts the filter from the zero state, so the same stimulus then repeats the output sequence seen after reset.
- R11: The output of a first-order modulator at input level u/1024 settles within 256 counts of u·16 on the 15-bit scale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flt_clr | input | 1 | Synchronous clear of the filter state and of the settle count |
| bit_en | input | 1 | Qualifies bit_in for one cycle |
| bit_in | input | 1 | Modulator bit: 1 means +1, 0 means −1 |
| fmt_mixed | input | 1 | Output format: 0 selects wide data, 1 selects flagged |
| smp_stb | output | 1 | One-cycle pulse when a new sample is presented |
| smp_ok | output | 1 | Sample is settled, qualified by smp_stb |
| smp_word | output | 16 | Formatted sample |

## Verification
The bench uses the default parameters: third order, decimation 32 and a 15-bit result. With these values the DC gain of 32768 lands exactly one code above the largest positive 15-bit value, so a stream of constant ones exercises the saturation path and a stream of constant zeros reaches the most negative code. Input streams with a period of four bits fit a whole number of times into 32 bits, so they give exact mid-scale values for the shift and flag checks. The behavioural modulator exercises nonperiodic bit patterns. Bits are paced at one per eight cycles, which makes the 256-cycle output rhythm visible at the ports.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

   typedef enum logic {
      FMT_WIDE    = 1'b0,
      FMT_FLAGGED = 1'b1
   } word_fmt_e;

   // Accumulator width: 2-bit signed input plus growth of order*log2(R)
   function automatic int acc_bits(input int order, input int dec_log2);
      return order * dec_log2 + 2;
   endfunction

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
   parameter int W      = 17,
   parameter int STAGES = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                clr,
   input  logic                en,
   input  logic signed [1:0]   step,
   output logic signed [W-1:0] sum
);
   logic signed [W-1:0] acc_q [STAGES];
   logic signed [W-1:0] feed  [STAGES];

   assign feed[0] = {{(W-2){step[1]}}, step};

   for (genvar gi = 1; gi < STAGES; gi++) begin : g_feed
      assign feed[gi] = acc_q[gi-1];
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         for (int i = 0; i < STAGES; i++) acc_q[i] <= '0;
      end else if (en) begin
         for (int i = 0; i < STAGES; i++) acc_q[i] <= acc_q[i] + feed[i];
      end
   end

   assign sum = acc_q[STAGES-1];
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
   parameter int W      = 17,
   parameter int STAGES = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                clr,
   input  logic                en,
   input  logic signed [W-1:0] din,
   output logic signed [W-1:0] dout,
   output logic                dout_stb
);
   logic signed [W-1:0] dly_q [STAGES];
   logic signed [W-1:0] diff  [STAGES+1];
   logic signed [W-1:0] dout_q;
   logic                stb_q;

   assign diff[0] = din;

   for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      assign diff[gi+1] = diff[gi] - dly_q[gi];
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         for (int i = 0; i < STAGES; i++) dly_q[i] <= '0;
         dout_q <= '0;
         stb_q  <= 1'b0;
      end else begin
         stb_q <= en;
         if (en) begin
            for (int i = 0; i < STAGES; i++) dly_q[i] <= diff[i];
            dout_q <= diff[STAGES];
         end
      end
   end

   assign dout     = dout_q;
   assign dout_stb = stb_q;
endmodule

// File: rtl/sinc3_fmt.sv
module sinc3_fmt
   import sinc3_pkg::*;
#(
   parameter int   ACC_W     = 17,
   parameter int   RES_W     = 15,
   parameter int   SHIFT     = 1,
   parameter logic FLAG_DATA = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clr,
   input  logic                    in_stb,
   input  logic                    in_ok,
   input  word_fmt_e               fmt,
   input  logic signed [ACC_W-1:0] acc,
   output logic [RES_W:0]          word,
   output logic                    stb,
   output logic                    ok
);
   localparam int WORD_W = RES_W + 1;

   logic signed [RES_W:0]   scaled;
   logic                    pos_over;
   logic [RES_W-1:0]        res;
   logic [WORD_W-1:0]       wide_w, flag_w;
   logic [WORD_W-1:0]       word_q;
   logic                    stb_q, ok_q;

   assign scaled = acc[ACC_W-1:SHIFT];

   if (SHIFT > 0) begin : g_drop
      logic unused_lsbs;
      assign unused_lsbs = ^acc[SHIFT-1:0];
   end

   assign pos_over = ~scaled[RES_W] & scaled[RES_W-1];
   assign res      = pos_over ? {1'b0, {(RES_W-1){1'b1}}} : scaled[RES_W-1:0];
   assign wide_w   = pos_over ? {1'b0, {RES_W{1'b1}}} : {res, 1'b0};
   assign flag_w   = {FLAG_DATA, res};

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         word_q <= '0;
         stb_q  <= 1'b0;
         ok_q   <= 1'b0;
      end else begin
         stb_q <= in_stb;
         ok_q  <= in_stb & in_ok;
         if (in_stb) word_q <= (fmt == FMT_FLAGGED) ? flag_w : wide_w;
      end
   end

   assign word = word_q;
   assign stb  = stb_q;
   assign ok   = ok_q;
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
   import sinc3_pkg::*;
#(
   parameter int   ORDER     = 3,
   parameter int   DEC_LOG2  = 5,
   parameter int   RES_W     = 15,
   parameter logic FLAG_DATA = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             flt_clr,
   input  logic             bit_en,
   input  logic             bit_in,
   input  logic             fmt_mixed,
   output logic             smp_stb,
   output logic             smp_ok,
   output logic [RES_W:0]   smp_word
);
   localparam int ACC_W  = acc_bits(ORDER, DEC_LOG2);
   localparam int SHIFT  = ORDER * DEC_LOG2 + 1 - RES_W;
   localparam int FILL_W = $clog2(ORDER + 1);

   if (ORDER < 1 || ORDER > 6) begin : g_bad_order
      $error("sinc3_decimator: ORDER must lie in 1..6");
   end
   if (DEC_LOG2 < 1 || DEC_LOG2 > 10) begin : g_bad_dec
      $error("sinc3_decimator: DEC_LOG2 must lie in 1..10");
   end
   if (SHIFT < 0 || RES_W < 2) begin : g_bad_res
      $error("sinc3_decimator: RES_W exceeds the filter growth");
   end

   logic [DEC_LOG2-1:0]     phase_q;
   logic                    dec_stb_q;
   logic signed [1:0]       step;
   logic signed [ACC_W-1:0] int_sum, comb_out;
   logic                    comb_stb;
   logic [FILL_W-1:0]       fill_q;
   logic                    settled;
   word_fmt_e               fmt;

   assign step = bit_in ? 2'sb01 : 2'sb11;
   assign fmt  = word_fmt_e'(fmt_mixed);

   always_ff @(posedge clk) begin
      if (rst || flt_clr) begin
         phase_q   <= '0;
         dec_stb_q <= 1'b0;
      end else begin
         dec_stb_q <= bit_en && (phase_q == '1);
         if (bit_en) phase_q <= phase_q + 1'b1;
      end
   end

   sinc3_integ #(.W(ACC_W), .STAGES(ORDER)) u_integ (
      .clk  (clk),
      .rst  (rst),
      .clr  (flt_clr),
      .en   (bit_en),
      .step (step),
      .sum  (int_sum)
   );

   sinc3_comb #(.W(ACC_W), .STAGES(ORDER)) u_comb (
      .clk      (clk),
      .rst      (rst),
      .clr      (flt_clr),
      .en       (dec_stb_q),
      .din      (int_sum),
      .dout     (comb_out),
      .dout_stb (comb_stb)
   );

   assign settled = (fill_q == FILL_W'(ORDER));

   always_ff @(posedge clk) begin
      if (rst || flt_clr)         fill_q <= '0;
      else if (comb_stb && !settled) fill_q <= fill_q + 1'b1;
   end

   sinc3_fmt #(
      .ACC_W(ACC_W), .RES_W(RES_W), .SHIFT(SHIFT), .FLAG_DATA(FLAG_DATA)
   ) u_fmt (
      .clk    (clk),
      .rst    (rst),
      .clr    (flt_clr),
      .in_stb (comb_stb),
      .in_ok  (settled),
      .fmt    (fmt),
      .acc    (comb_out),
      .word   (smp_word),
      .stb    (smp_stb),
      .ok     (smp_ok)
   );
endmodule

// File: rtl/sinc3_decimator_chk.sv
module sinc3_decimator_chk #(
   parameter int   ORDER     = 3,
   parameter int   WORD_W    = 16,
   parameter logic FLAG_DATA = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              flt_clr,
   input logic              fmt_mixed,
   input logic              smp_stb,
   input logic              smp_ok,
   input logic [WORD_W-1:0] smp_word
);
   localparam int SEEN_W = $clog2(ORDER + 1);
   localparam logic [SEEN_W-1:0] SEEN_MAX = SEEN_W'(ORDER);

   logic [SEEN_W-1:0] seen_q;

   always_ff @(posedge clk) begin
      if (rst || flt_clr)                 seen_q <= '0;
      else if (smp_stb && seen_q < SEEN_MAX) seen_q <= seen_q + 1'b1;
   end

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
      smp_stb |=> !smp_stb);                                          // R2
   AST_OK_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
      smp_ok |-> smp_stb);                                            // R9
   AST_EARLY_UNSETTLED: assert property (@(posedge clk) disable iff (rst)
      (smp_stb && seen_q < SEEN_MAX) |-> !smp_ok);                    // R9
   AST_LATE_SETTLED: assert property (@(posedge clk) disable iff (rst)
      (smp_stb && seen_q == SEEN_MAX) |-> smp_ok);                    // R9
   AST_WIDE_LSB: assert property (@(posedge clk) disable iff (rst)
      (smp_stb && !$past(fmt_mixed)) |->
      (!smp_word[0] || smp_word == {1'b0, {(WORD_W-1){1'b1}}}));      // R6
   AST_FLAG_BIT: assert property (@(posedge clk) disable iff (rst)
      (smp_stb && $past(fmt_mixed)) |-> smp_word[WORD_W-1] == FLAG_DATA); // R7
   AST_CLR_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(flt_clr) |-> !smp_stb);                                   // R10
endmodule

bind sinc3_decimator sinc3_decimator_chk #(
   .ORDER(ORDER), .WORD_W(RES_W + 1), .FLAG_DATA(FLAG_DATA)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .flt_clr   (flt_clr),
   .fmt_mixed (fmt_mixed),
   .smp_stb   (smp_stb),
   .smp_ok    (smp_ok),
   .smp_word  (smp_word)
);

// File: tb/tb_sinc3_decimator.sv
`timescale 1ns/1ps
module tb_sinc3_decimator;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        flt_clr = 1'b0;
   logic        bit_en = 1'b0;
   logic        bit_in = 1'b0;
   logic        fmt_mixed = 1'b0;
   logic        smp_stb, smp_ok;
   logic [15:0] smp_word;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int nrec = 0;
   logic [15:0] words [64];
   logic        oks   [64];
   int          stamps[64];
   logic [15:0] saved [3];
   int          macc = 0;

   always #4 clk = ~clk;

   sinc3_decimator dut (
      .clk(clk), .rst(rst), .flt_clr(flt_clr), .bit_en(bit_en), .bit_in(bit_in),
      .fmt_mixed(fmt_mixed), .smp_stb(smp_stb), .smp_ok(smp_ok), .smp_word(smp_word)
   );

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (smp_stb && nrec < 64) begin
         words[nrec]  = smp_word;
         oks[nrec]    = smp_ok;
         stamps[nrec] = cyc;
         nrec++;
      end
   end

   task automatic chk(input bit cond, input string tag, input int act, input int exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic bit pat(input int kind, input int idx);
      case (kind)
         0: return 1'b1;
         1: return 1'b0;
         2: return idx[0];
         3: return (idx % 4) != 0;
         default: return (idx % 4) == 0;
      endcase
   endfunction

   // one bit per 8 cycles; off-enable cycles carry the inverted bit (R3)
   task automatic drive_bit(input bit b);
      @(negedge clk);
      bit_en = 1'b1; bit_in = b;
      @(negedge clk);
      bit_en = 1'b0; bit_in = ~b;
      repeat (6) @(negedge clk);
   endtask

   task automatic do_clear();
      @(negedge clk);
      flt_clr = 1'b1;
      @(negedge clk);
      flt_clr = 1'b0;
      nrec = 0;
   endtask

   task automatic run(input int kind, input int nbits, input bit fmt, input bit clr);
      fmt_mixed = fmt;
      if (clr) do_clear();
      for (int i = 0; i < nbits; i++) drive_bit(pat(kind, i));
      repeat (16) @(negedge clk);
   endtask

   task automatic run_mod(input int u, input int nbits);
      fmt_mixed = 1'b1;
      do_clear();
      macc = 0;
      for (int i = 0; i < nbits; i++) begin
         bit y = (macc >= 0);
         macc += u - (y ? 1024 : -1024);
         drive_bit(y);
      end
      repeat (16) @(negedge clk);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      repeat (20) @(negedge clk);
      chk(smp_stb == 1'b0, "R1 stb after reset", smp_stb, 0);
      chk(smp_ok == 1'b0, "R1 ok after reset", smp_ok, 0);
      chk(smp_word == 16'h0, "R1 word after reset", smp_word, 0);
      chk(nrec == 0, "R1 no pulses while idle", nrec, 0);
   endtask

   task automatic t_ones_wide();
      run(0, 192, 1'b0, 1'b0);
      chk(nrec == 6, "R2 pulse count for 192 bits", nrec, 6);
      chk(stamps[5] - stamps[4] == 256, "R2 pulse spacing", stamps[5] - stamps[4], 256);
      chk(oks[0] == 0 && oks[1] == 0 && oks[2] == 0, "R9 first three unsettled",
          {oks[0], oks[1], oks[2]}, 0);
      chk(oks[3] == 1, "R9 fourth settled", oks[3], 1);
      chk(words[3] == 16'h7FFF, "R4 R3 ones wide", words[3], 16'h7FFF);
      chk(words[5] == 16'h7FFF, "R4 ones wide later", words[5], 16'h7FFF);
      for (int k = 0; k < 3; k++) saved[k] = words[k];
   endtask

   task automatic t_ones_flag();
      run(0, 192, 1'b1, 1'b1);
      chk(words[4] == 16'h3FFF, "R4 ones flagged", words[4], 16'h3FFF);
   endtask

   task automatic t_zeros();
      run(1, 192, 1'b0, 1'b1);
      chk(words[4] == 16'h8000, "R5 zeros wide", words[4], 16'h8000);
      run(1, 192, 1'b1, 1'b1);
      chk(words[4] == 16'h4000, "R5 zeros flagged", words[4], 16'h4000);
   endtask

   task automatic t_alternate();
      run(2, 192, 1'b0, 1'b1);
      chk(words[4] == 16'h0000, "R8 alternating wide", words[4], 0);
      run(2, 192, 1'b1, 1'b1);
      chk(words[5] == 16'h0000, "R8 alternating flagged", words[5], 0);
   endtask

   task automatic t_duty();
      run(3, 192, 1'b0, 1'b1);
      chk(words[4] == 16'h4000, "R6 three-quarter wide", words[4], 16'h4000);
      run(3, 192, 1'b1, 1'b1);
      chk(words[4] == 16'h2000, "R7 three-quarter flagged", words[4], 16'h2000);
      run(4, 192, 1'b0, 1'b1);
      chk(words[4] == 16'hC000, "R6 quarter wide", words[4], 16'hC000);
      run(4, 192, 1'b1, 1'b1);
      chk(words[4] == 16'h6000, "R7 quarter flagged", words[4], 16'h6000);
   endtask

   task automatic t_clear();
      run(1, 40, 1'b0, 1'b1);
      run(0, 192, 1'b0, 1'b1);
      chk(nrec == 6, "R10 pulse count after clear", nrec, 6);
      for (int k = 0; k < 3; k++)
         chk(words[k] == saved[k], "R10 restart matches reset sequence", words[k], saved[k]);
      chk(oks[2] == 0 && oks[3] == 1, "R9 settle restarts after clear",
          {oks[2], oks[3]}, 1);
   endtask

   task automatic t_modulator();
      int v;
      run_mod(300, 224);
      v = int'($signed(words[5][14:0]));
      chk(v > 4800 - 256 && v < 4800 + 256, "R11 modulator +300", v, 4800);
      run_mod(-700, 224);
      v = int'($signed(words[5][14:0]));
      chk(v > -11200 - 256 && v < -11200 + 256, "R11 modulator -700", v, -11200);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_ones_wide();
      t_ones_flag();
      t_zeros();
      t_alternate();
      t_duty();
      t_clear();
      t_modulator();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule